// File: doc/BRIEF.md
# Fractional-Resolution Dithered PWM Timer

A single-channel, single-slope PWM counter whose period and high time can be set in fractions of a clock. A resolution mode picks a dither frame of 16, 32 or 64 PWM cycles. The period register and the compare register each carry an integer part and a small dither increment. Across one frame, exactly as many PWM cycles as the increment are lengthened by one clock. This makes the period and high time average to a fractional number of clocks. The stretched cycles are spread evenly through the frame, which keeps low-frequency flicker small.

A fixed multiply-mask-compare rule selects which cycles are lengthened. The rule is evaluated independently for the period and for the compare value. Register and mode inputs are sampled only at a cycle boundary, so software may write them at any time. With dithering off, both registers are plain integers.

Top module: `dpwm_timer`

## Requirements
- R1: While rst_ni is low, and for the first clock after it rises, pwm_o and cyc_end_o are 0. The first PWM cycle starts on the following clock with frame index 0.
- R2: With mode_i = 0 (off), each cycle lasts per_i+1 clocks and pwm_o is high for the first cmp_i clocks. All register bits form the integer value, and no clock is ever inserted.
- R3: mode_i = 1, 2 and 3 select frames of N = 16, 32 and 64 cycles. The dither increment d is held in the low 4, 5 or 6 bits of a register, and the integer part is in the bits above.
- R4: A cycle with frame index c is one clock longer than per_int+1 exactly when ((c*d_per) mod N) + d_per > N-1.
- R5: The high time of a cycle is cmp_int + e, where e is 1 exactly when ((c*d_cmp) mod N) + d_cmp > N-1. This is independent of the period rule.
- R6: Over a whole frame with constant settings, the total clock count is N*(per_int+1)+d_per and the total high time is N*cmp_int+d_cmp.
- R7: The frame index advances by one at each cycle end and wraps from N-1 to 0. It restarts at 0 when a new mode is taken in.
- R8: per_i, cmp_i and mode_i are sampled only on the last clock of a cycle. Changes at other times do not affect the cycle in progress.
- R9: cyc_end_o is high on exactly the last clock of every PWM cycle.
- R10: pwm_o is high from the first clock of a cycle for the high time. If the high time reaches or passes the cycle length, pwm_o is high for the whole cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Resolution mode: 0 off, 1/2/3 = 16/32/64-cycle frame |
| per_i | input | CNT_W | Period register (integer part and dither increment) |
| cmp_i | input | CNT_W | Compare register (integer part and dither increment) |
| pwm_o | output | 1 | PWM waveform |
| cyc_end_o | output | 1 | High on the last clock of each PWM cycle |

## Verification
The bound checker enforces properties that must hold on every cycle:
- outputs stay quiet before the first cycle;
- the counter stays inside the current period;
- a cycle end returns the counter to zero;
- the frame index stays inside the frame and steps correctly;
- sampled settings stay frozen within a cycle;
- no insertion happens with dithering off.

Which cycles are stretched, and whether the frame totals come out as N*(per_int+1)+d, can only be shown by the bench. The bench runs whole frames for several modes and increments. It compares both outputs on every clock against a behavioural model, measures stretched cycles from the waveform, and checks a known stretch pattern for d=5 and d=9 in a 16-cycle frame.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  localparam int DITH_W = 6;

  typedef enum logic [1:0] {
    RES_OFF = 2'd0,
    RES_F16 = 2'd1,
    RES_F32 = 2'd2,
    RES_F64 = 2'd3
  } res_mode_e;

  function automatic logic [DITH_W-1:0] frame_mask(res_mode_e m);
    case (m)
      RES_F16: return DITH_W'(6'h0f);
      RES_F32: return DITH_W'(6'h1f);
      RES_F64: return DITH_W'(6'h3f);
      default: return '0;
    endcase
  endfunction

  function automatic int unsigned dith_bits(res_mode_e m);
    case (m)
      RES_F16: return 4;
      RES_F32: return 5;
      RES_F64: return 6;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/dpwm_split.sv
// Splits a register into integer part and dither increment per mode.
module dpwm_split
  import dpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  res_mode_e         mode_i,
  input  logic [CNT_W-1:0]  reg_i,
  output logic [CNT_W-1:0]  int_o,
  output logic [DITH_W-1:0] dith_o
);
  always_comb begin
    int_o  = reg_i >> dith_bits(mode_i);
    dith_o = reg_i[DITH_W-1:0] & frame_mask(mode_i);
  end
endmodule

// File: rtl/dpwm_dither.sv
// One-clock insertion decision for the current frame index.
module dpwm_dither
  import dpwm_pkg::*;
(
  input  logic [DITH_W-1:0] frm_i,
  input  logic [DITH_W-1:0] dith_i,
  input  logic [DITH_W-1:0] mask_i,
  output logic              ext_o
);
  logic [DITH_W-1:0] prod_lo;
  logic [DITH_W:0]   sum;

  always_comb begin
    prod_lo = frm_i * dith_i;  // only bits under the mask matter
    sum     = {1'b0, prod_lo & mask_i} + {1'b0, dith_i};
    ext_o   = sum > {1'b0, mask_i};
  end
endmodule

// File: rtl/dpwm_timer.sv
module dpwm_timer
  import dpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic             pwm_o,
  output logic             cyc_end_o
);
  localparam int LEN_W = CNT_W + 1;
  localparam int NCH   = 2;  // 0: period, 1: compare

  res_mode_e                     mode_q, mode_in;
  logic                          run_q;
  logic [LEN_W-1:0]              cnt_q, per_len, hi_len;
  logic [DITH_W-1:0]             frm_q, mask_w;
  logic [NCH-1:0][CNT_W-1:0]     reg_w, shd_q, int_w;
  logic [NCH-1:0][DITH_W-1:0]    dith_w;
  logic [NCH-1:0]                ext_w;
  logic                          last_w;

  assign mode_in  = res_mode_e'(mode_i);
  assign reg_w[0] = per_i;
  assign reg_w[1] = cmp_i;
  assign mask_w   = frame_mask(mode_q);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dpwm_split #(.CNT_W(CNT_W)) u_split (
      .mode_i (mode_q),
      .reg_i  (shd_q[g]),
      .int_o  (int_w[g]),
      .dith_o (dith_w[g])
    );
    dpwm_dither u_dith (
      .frm_i  (frm_q),
      .dith_i (dith_w[g]),
      .mask_i (mask_w),
      .ext_o  (ext_w[g])
    );
  end

  assign per_len   = {1'b0, int_w[0]} + LEN_W'(1) + LEN_W'(ext_w[0]);
  assign hi_len    = {1'b0, int_w[1]} + LEN_W'(ext_w[1]);
  assign last_w    = cnt_q == per_len - LEN_W'(1);
  assign cyc_end_o = run_q && last_w;
  assign pwm_o     = run_q && (cnt_q < hi_len);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      frm_q  <= '0;
      mode_q <= RES_OFF;
      shd_q  <= '0;
    end else if (!run_q || last_w) begin
      // cycle boundary: take in new settings
      run_q  <= 1'b1;
      cnt_q  <= '0;
      shd_q  <= reg_w;
      mode_q <= mode_in;
      if (!run_q || mode_in != mode_q || frm_q == mask_w) frm_q <= '0;
      else                                                frm_q <= frm_q + DITH_W'(1);
    end else begin
      cnt_q <= cnt_q + LEN_W'(1);
    end
  end
endmodule

// File: rtl/dpwm_timer_chk.sv
module dpwm_timer_chk
  import dpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               run_q,
  input logic [CNT_W:0]     cnt_q,
  input logic [CNT_W:0]     per_len,
  input logic [DITH_W-1:0]  frm_q,
  input logic [DITH_W-1:0]  mask_w,
  input res_mode_e          mode_q,
  input logic [2*CNT_W-1:0] shd_q,
  input logic [1:0]         ext_w,
  input logic               pwm_o,
  input logic               cyc_end_o
);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> (!pwm_o && !cyc_end_o));

  p_off_plain_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == RES_OFF) |-> (ext_w == 2'b00 && frm_q == '0));

  p_frame_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_q <= mask_w);

  p_frame_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !cyc_end_o) |=> $stable(frm_q));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !cyc_end_o) |=> ($stable(shd_q) && $stable(mode_q)));

  p_cnt_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (cnt_q < per_len));

  p_end_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_end_o |=> (cnt_q == '0 && run_q));
endmodule

bind dpwm_timer dpwm_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .run_q     (run_q),
  .cnt_q     (cnt_q),
  .per_len   (per_len),
  .frm_q     (frm_q),
  .mask_w    (mask_w),
  .mode_q    (mode_q),
  .shd_q     (shd_q),
  .ext_w     (ext_w),
  .pwm_o     (pwm_o),
  .cyc_end_o (cyc_end_o)
);

// File: tb/tb_dpwm_timer.sv
module tb_dpwm_timer;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       mode = 2'd0;
  logic [CNT_W-1:0] per = '0, cmp = '0;
  logic             pwm, cyc_end;

  int total = 0, bad = 0;
  int clocks = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  dpwm_timer #(.CNT_W(CNT_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
    .per_i(per), .cmp_i(cmp), .pwm_o(pwm), .cyc_end_o(cyc_end)
  );

  // reference model state
  bit primed = 0;
  int m_mode, m_n, m_p, m_dp, m_c_int, m_dc, c, pos, len, hi;
  int m_per, m_cmp;
  int acc_len, acc_hi, meas_len, meas_hi, frames_ok;
  bit dirty;
  longint pm_acc, cm_acc, last_pm, last_cm;

  function automatic int extra(int ci, int d, int n);
    return (((ci * d) % n) + d) > (n - 1) ? 1 : 0;
  endfunction

  function automatic int frame_n(int md);
    return md == 0 ? 1 : (1 << (md + 3));
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  task automatic latch_regs();
    int nb;
    m_mode = int'(mode);
    m_per  = int'(per);
    m_cmp  = int'(cmp);
    m_n    = frame_n(m_mode);
    nb     = m_mode == 0 ? 0 : m_mode + 3;
    m_p    = m_per >> nb;
    m_dp   = m_per & (m_n - 1);
    m_c_int = m_cmp >> nb;
    m_dc   = m_cmp & (m_n - 1);
  endtask

  task automatic start_cycle();
    pos = 0;
    len = m_p + 1 + extra(c, m_dp, m_n);
    hi  = m_c_int + extra(c, m_dc, m_n);
  endtask

  always @(negedge clk) begin
    if (!done) begin
      clocks++;
      if (!rst_n) begin
        primed = 0;
        check("R1 pwm in reset", int'(pwm), 0);
        check("R1 end in reset", int'(cyc_end), 0);
      end else if (!primed) begin
        check("R1 pwm first clock", int'(pwm), 0);
        check("R1 end first clock", int'(cyc_end), 0);
        primed = 1;
        latch_regs();
        c = 0; acc_len = 0; acc_hi = 0; meas_len = 0; meas_hi = 0;
        pm_acc = 0; cm_acc = 0; dirty = 0;
        start_cycle();
      end else begin
        // R9/R10 per-clock comparison; R2/R4/R5 shape the expected len/hi
        check("R10 pwm", int'(pwm), (pos < hi) ? 1 : 0);
        check("R9 cyc_end", int'(cyc_end), (pos == len - 1) ? 1 : 0);
        acc_len++;
        acc_hi += (pos < hi) ? 1 : 0;
        meas_len++;
        meas_hi += int'(pwm);
        if (cyc_end) begin
          if (meas_len > m_p + 1) pm_acc[c] = 1'b1;
          if (meas_hi > m_c_int)  cm_acc[c] = 1'b1;
          meas_len = 0; meas_hi = 0;
        end
        if (pos == len - 1) begin
          int old_mode, old_per, old_cmp;
          if (c == m_n - 1 && m_n > 1 && !dirty) begin
            check("R6 frame clocks", acc_len, m_n * (m_p + 1) + m_dp);
            check("R6 frame high", acc_hi, m_n * m_c_int + m_dc);
            last_pm = pm_acc; last_cm = cm_acc;
            frames_ok++;
          end
          old_mode = m_mode; old_per = m_per; old_cmp = m_cmp;
          // R7: advance / wrap / restart on mode change
          if (int'(mode) != m_mode) c = 0;
          else c = (c + 1) % m_n;
          latch_regs();
          if (c == 0) begin
            acc_len = 0; acc_hi = 0; pm_acc = 0; cm_acc = 0; dirty = 0;
          end else if (old_mode != m_mode || old_per != m_per || old_cmp != m_cmp) begin
            dirty = 1;
          end
          start_cycle();
        end else begin
          pos++;
        end
      end
      if (clocks > 150000) begin
        bad++; total++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_end();
    @(negedge clk);
    while (!cyc_end) @(negedge clk);
    @(posedge clk);
    #1;
  endtask

  initial begin
    int fr0;
    // R1: reset, then R2 off mode (per 9, cmp 4)
    mode = 2'd0; per = 16'd9; cmp = 16'd4;
    step(3);
    rst_n = 1'b1;
    step(60);
    // R8: mid-cycle write has no effect on the cycle in progress
    step(3);
    cmp = 16'd7;
    step(40);
    // R3/R4/R5: 16-cycle frame, per int 7 d 5, cmp int 3 d 9
    mode = 2'd1; per = (16'd7 << 4) | 16'd5; cmp = (16'd3 << 4) | 16'd9;
    fr0 = frames_ok;
    step(3 * (16 * 8 + 5) + 20);
    check("R6 frames seen", (frames_ok > fr0) ? 1 : 0, 1);
    check("R4 stretched cycles d=5 N=16", int'(last_pm[15:0]), 16'h9248);
    check("R5 high-stretched cycles d=9 N=16", int'(last_cm[15:0]), 16'hd5aa);
    // R8: change compare mid-frame, then settle
    step(17);
    cmp = (16'd2 << 4) | 16'd3;
    step(400);
    // R3: 32-cycle frame, per int 5 d 31, cmp int 2 d 1
    mode = 2'd2; per = (16'd5 << 5) | 16'd31; cmp = (16'd2 << 5) | 16'd1;
    fr0 = frames_ok;
    step(3 * (32 * 6 + 31) + 20);
    check("R6 frames seen 32", (frames_ok > fr0) ? 1 : 0, 1);
    // R3: 64-cycle frame, per int 4 d 1, cmp int 4 d 63
    mode = 2'd3; per = (16'd4 << 6) | 16'd1; cmp = (16'd4 << 6) | 16'd63;
    fr0 = frames_ok;
    step(3 * (64 * 5 + 1) + 20);
    check("R6 frames seen 64", (frames_ok > fr0) ? 1 : 0, 1);
    check("R4 single stretch d=1 N=64", int'($countones(last_pm)), 1);
    // R4: zero increment -> no stretching
    mode = 2'd1; per = (16'd7 << 4); cmp = (16'd3 << 4) | 16'd15;
    step(3 * 16 * 8 + 20);
    check("R4 no stretch d=0", int'(last_pm[15:0]), 0);
    // R10: compare beyond period -> high whole cycle; compare 0 -> low
    mode = 2'd0; per = 16'd3; cmp = 16'd10;
    step(40);
    wait_end();
    check("R10 full-high sample", int'(pwm), 1);
    cmp = 16'd0;
    step(20);
    wait_end();
    step(1);
    check("R10 zero-high sample", int'(pwm), 0);
    step(5);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule